// File: doc/BRIEF.md
# System-Control Register Unit with Mode Stack and Exception Entry

This block is the privileged control register file that sits beside the integer pipeline of a 32-bit RISC core. It holds a bank of general control registers. Move-from operations read them and move-to operations write them. Three of the registers behave specially. The mode word at index 12 keeps a three-deep stack of two-bit privilege/interrupt-enable pairs in its low six bits. The event register at index 13 records why the last trap happened and holds the software interrupt pending bits. The return-address register at index 14 is loaded when a trap is taken.

The pipeline uses the block in four ways. It reads a register combinationally for a move-from operation and is told whether the result may be written back to the general register file. It writes a register on the clock edge for a move-to operation. It pulses a return strobe to pop the mode stack. It pulses a trap strobe, with a five-bit code, the faulting instruction address and a delay-slot flag, to push the stack and record the trap. If a write to the event register leaves a software interrupt both pending and enabled while interrupts are globally on, the block raises an interrupt request on the next cycle.

Top module: `sc_unit`

## Requirements
- R1: A return strobe (rfeEn) loads mode bits 3:0 with the old mode bits 5:2. Mode bits 31:4 keep their values.
- R2: A move-to write to index 13 stores the data with bits 15:10 cleared. All other bits are stored as given.
- R3: irqReq is high for exactly the one cycle after an index-13 write is performed, and only when (new event value AND mode word before the write AND 0x300) is nonzero and mode bit 0 was set before the write. Otherwise it is low.
- R4: A performed move-to write to any index other than 13 stores the full 32-bit value unchanged, including index 12 and index 14.
- R5: rdData shows the register selected by rdIdx in the same cycle. A write becomes visible right after its clock edge.
- R6: A trap strobe (excEn) moves mode bits 3:0 into bits 5:2 and clears bits 1:0. Bits 31:6 are unchanged.
- R7: A trap strobe sets index 13 to {excSlot, 24 zero bits, excCode, 2'b00}, so code 8 yields 0x20. It sets index 14 to excPc, or to excPc-4 when excSlot is set.
- R8: gprWe is high only when rdEn is high and rdDest is nonzero.
- R9: In a trap cycle, move-to writes and the return strobe are discarded. In a return cycle, a move-to write to index 12 is discarded, while writes to other indices still take effect.
- R10: After reset every register reads zero and irqReq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdIdx | input | 5 | Register index for the move-from read |
| rdEn | input | 1 | Move-from operation is present |
| rdDest | input | 5 | Destination general register of the move-from |
| rdData | output | 32 | Combinational read data |
| gprWe | output | 1 | Move-from result may be written back |
| wrEn | input | 1 | Move-to write strobe |
| wrIdx | input | 5 | Move-to register index |
| wrData | input | 32 | Move-to write data |
| rfeEn | input | 1 | Return-from-trap strobe |
| excEn | input | 1 | Trap entry strobe |
| excCode | input | 5 | Trap code |
| excSlot | input | 1 | Trap happened in a branch delay slot |
| excPc | input | 32 | Address of the trapping instruction |
| irqReq | output | 1 | Software interrupt request pulse |

## Verification
The assertions assume that the strobes are single-cycle, clean and known after reset. They also assume that excPc is a word address and that the index inputs stay inside the register count. The random stimulus meets these assumptions by construction. It draws indices from the full five-bit range, favouring 12, 13 and 14. It raises the strobes with moderate probability, so that a trap, a return and a write often coincide. Directed cases add the coincidences that random draws might miss: a trap with a write, a return with an index-12 write, and an event-register write that does and does not trigger an interrupt.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int STATUS_IDX = 12;
  localparam int CAUSE_IDX  = 13;
  localparam int EPC_IDX    = 14;

  typedef struct packed {
    logic regWr;    // move-to write is performed
    logic causeWr;  // performed write targets the event register
    logic rfePop;   // pop the mode stack
    logic excPush;  // trap entry
  } scStrobes_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [AW-1:0]       wrIdx,
  input  logic [DW-1:0]       wrData,
  input  logic                rfeEn,
  input  logic                excEn,
  input  logic                rdEn,
  input  logic [AW-1:0]       rdDest,
  input  logic [DW-1:0]       statusQ,
  output sc_pkg::scStrobes_t  strobes,
  output logic                gprWe,
  output logic                irqReq
);
  import sc_pkg::*;

  localparam logic [DW-1:0] SW_IRQ_BITS = DW'(32'h0000_0300);

  logic statusBlocked;
  logic irqNext;

  always_comb begin
    statusBlocked   = rfeEn && (int'(wrIdx) == STATUS_IDX);
    strobes.excPush = excEn;
    strobes.rfePop  = rfeEn && !excEn;
    strobes.regWr   = wrEn && !excEn && !statusBlocked;
    strobes.causeWr = strobes.regWr && (int'(wrIdx) == CAUSE_IDX);
    irqNext = strobes.causeWr && statusQ[0] &&
              (|(wrData & statusQ & SW_IRQ_BITS));
    gprWe = rdEn && (rdDest != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqReq <= 1'b0;
    else       irqReq <= irqNext;
  end
endmodule

// File: rtl/sc_regs.sv
module sc_regs #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int AW   = 5,
  parameter int CW   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  sc_pkg::scStrobes_t  strobes,
  input  logic [AW-1:0]       wrIdx,
  input  logic [DW-1:0]       wrData,
  input  logic [CW-1:0]       excCode,
  input  logic                excSlot,
  input  logic [DW-1:0]       excPc,
  input  logic [AW-1:0]       rdIdx,
  output logic [DW-1:0]       rdData,
  output logic [DW-1:0]       statusQ,
  output logic [DW-1:0]       causeQ,
  output logic [DW-1:0]       epcQ
);
  import sc_pkg::*;

  localparam logic [DW-1:0] CAUSE_KEEP = ~DW'(32'h0000_FC00);
  localparam int PAD = DW - 1 - CW - 2;

  logic [DW-1:0] regQ [NREG];

  for (genvar g = 0; g < NREG; g++) begin : gReg
    logic hit;
    assign hit = strobes.regWr && (int'(wrIdx) == g);
    if (g == STATUS_IDX) begin : gStatus
      always_ff @(posedge clk) begin
        if (!rstN) regQ[g] <= '0;
        else if (strobes.excPush) regQ[g] <= {regQ[g][DW-1:6], regQ[g][3:0], 2'b00};
        else if (strobes.rfePop)  regQ[g] <= {regQ[g][DW-1:4], regQ[g][5:2]};
        else if (hit)             regQ[g] <= wrData;
      end
    end else if (g == CAUSE_IDX) begin : gCause
      always_ff @(posedge clk) begin
        if (!rstN) regQ[g] <= '0;
        else if (strobes.excPush) regQ[g] <= {excSlot, {PAD{1'b0}}, excCode, 2'b00};
        else if (hit)             regQ[g] <= wrData & CAUSE_KEEP;
      end
    end else if (g == EPC_IDX) begin : gEpc
      always_ff @(posedge clk) begin
        if (!rstN) regQ[g] <= '0;
        else if (strobes.excPush) regQ[g] <= excSlot ? excPc - DW'(4) : excPc;
        else if (hit)             regQ[g] <= wrData;
      end
    end else begin : gPlain
      always_ff @(posedge clk) begin
        if (!rstN)    regQ[g] <= '0;
        else if (hit) regQ[g] <= wrData;
      end
    end
  end

  assign rdData  = regQ[rdIdx];
  assign statusQ = regQ[STATUS_IDX];
  assign causeQ  = regQ[CAUSE_IDX];
  assign epcQ    = regQ[EPC_IDX];
endmodule

// File: rtl/sc_unit.sv
module sc_unit #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int CW   = 5,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] rdIdx,
  input  logic          rdEn,
  input  logic [AW-1:0] rdDest,
  output logic [DW-1:0] rdData,
  output logic          gprWe,
  input  logic          wrEn,
  input  logic [AW-1:0] wrIdx,
  input  logic [DW-1:0] wrData,
  input  logic          rfeEn,
  input  logic          excEn,
  input  logic [CW-1:0] excCode,
  input  logic          excSlot,
  input  logic [DW-1:0] excPc,
  output logic          irqReq
);
  sc_pkg::scStrobes_t strobes;
  logic [DW-1:0] statusQ;
  logic [DW-1:0] causeQ;
  logic [DW-1:0] epcQ;

  sc_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rfeEn(rfeEn), .excEn(excEn), .rdEn(rdEn), .rdDest(rdDest),
    .statusQ(statusQ), .strobes(strobes), .gprWe(gprWe), .irqReq(irqReq)
  );

  sc_regs #(.DW(DW), .NREG(NREG), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx), .wrData(wrData),
    .excCode(excCode), .excSlot(excSlot), .excPc(excPc), .rdIdx(rdIdx),
    .rdData(rdData), .statusQ(statusQ), .causeQ(causeQ), .epcQ(epcQ)
  );
endmodule

// File: rtl/sc_unit_chk.sv
module sc_unit_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [AW-1:0] wrIdx,
  input logic          rfeEn,
  input logic          excEn,
  input logic          excSlot,
  input logic [DW-1:0] excPc,
  input logic [DW-1:0] statusQ,
  input logic [DW-1:0] causeQ,
  input logic [DW-1:0] epcQ,
  input logic          irqReq
);
  AST_RFE_POP: assert property (@(posedge clk) disable iff (!rstN)
    (rfeEn && !excEn) |=> (statusQ[3:0] == $past(statusQ[5:2]) &&
                           statusQ[DW-1:4] == $past(statusQ[DW-1:4]))); // R1

  AST_CAUSE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !excEn && wrIdx == AW'(13)) |=> (causeQ[15:10] == 6'd0)); // R2

  AST_IRQ_COND: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ($past(statusQ[0]) && $past(wrEn && !excEn && wrIdx == AW'(13)) &&
                ((causeQ & $past(statusQ) & DW'(32'h300)) != '0))); // R3

  AST_EXC_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    excEn |=> (statusQ[5:2] == $past(statusQ[3:0]) && statusQ[1:0] == 2'b00)); // R6

  AST_EPC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (excEn && !excSlot) |=> (epcQ == $past(excPc))); // R7
endmodule

bind sc_unit sc_unit_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sim_sc_unit.sv
`timescale 1ns/1ps
module sim_sc_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdIdx = '0;
  logic        rdEn = 1'b0;
  logic [4:0]  rdDest = '0;
  logic [31:0] rdData;
  logic        gprWe;
  logic        wrEn = 1'b0;
  logic [4:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        rfeEn = 1'b0;
  logic        excEn = 1'b0;
  logic [4:0]  excCode = '0;
  logic        excSlot = 1'b0;
  logic [31:0] excPc = '0;
  logic        irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] mdl [32];
  logic expIrq = 1'b0;

  always #2.5 clk = ~clk;

  sc_unit u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model update for one cycle, from the requirements
  task automatic modelStep();
    logic [31:0] st;
    st = mdl[12];
    expIrq = 1'b0;
    if (excEn) begin
      mdl[12] = {st[31:6], st[3:0], 2'b00};
      mdl[13] = {excSlot, 24'd0, excCode, 2'b00};
      mdl[14] = excSlot ? excPc - 32'd4 : excPc;
    end else begin
      if (rfeEn) mdl[12] = {st[31:4], st[5:2]};
      if (wrEn && !(rfeEn && wrIdx == 5'd12)) begin
        if (wrIdx == 5'd13) begin
          mdl[13] = wrData & ~32'h0000FC00;
          expIrq = st[0] && ((mdl[13] & st & 32'h300) != 0);
        end else mdl[wrIdx] = wrData;
      end
    end
  endtask

  // Drive at negedge, clock, then check read, irq and writeback gate
  task automatic cycle(string tag, logic [4:0] probe);
    modelStep();
    @(posedge clk);
    #1;
    wrEn = 0; rfeEn = 0; excEn = 0;
    rdIdx = probe;
    #0.5;
    check({tag, " R5 read"}, rdData, mdl[probe]);
    check({tag, " R3 irqReq"}, {31'd0, irqReq}, {31'd0, expIrq});
    rdEn = $urandom_range(0, 1);
    rdDest = $urandom_range(0, 3) == 0 ? 5'd0 : 5'($urandom);
    #0.5;
    check({tag, " R8 gprWe"}, {31'd0, gprWe}, {31'd0, rdEn && rdDest != 0});
    @(negedge clk);
  endtask

  task automatic doWrite(logic [4:0] i, logic [31:0] d, string tag);
    wrEn = 1; wrIdx = i; wrData = d;
    cycle(tag, i);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    for (int i = 0; i < 32; i++) begin
      rdIdx = 5'(i);
      #0.1;
      check("R10 reset read", rdData, 32'd0);
    end
    check("R10 reset irqReq", {31'd0, irqReq}, 32'd0);
    @(negedge clk);

    // R4: full-value writes
    doWrite(5'd12, 32'hFFFF_FF2D, "R4 status write");
    doWrite(5'd14, 32'hDEAD_BEEF, "R4 epc write");
    doWrite(5'd3,  32'h1234_5678, "R4 plain write");
    // R1: return pops stack (0x2D = 10_11_01)
    rfeEn = 1; cycle("R1 rfe", 5'd12);
    check("R1 value", mdl[12], 32'hFFFF_FF2B);
    // R2, R3: event write with pending+enabled bit, irq on (status bit0=1)
    doWrite(5'd13, 32'hFFFF_FFFF, "R2 R3 cause write irq");
    check("R2 masked value", mdl[13], 32'hFFFF_03FF);
    // R3: no irq when pending bits absent
    doWrite(5'd13, 32'h0000_00FC, "R3 cause write no irq");
    // R3: no irq when global enable off
    doWrite(5'd12, 32'h0000_0300, "R4 status irq off");
    doWrite(5'd13, 32'h0000_0300, "R3 cause write disabled");
    // R6, R7: trap entry with write in same cycle (R9)
    doWrite(5'd12, 32'h0000_000F, "R4 status set");
    excEn = 1; excCode = 5'd8; excSlot = 0; excPc = 32'h0000_1000;
    wrEn = 1; wrIdx = 5'd5; wrData = 32'hAAAA_5555; rfeEn = 1;
    cycle("R6 R9 trap", 5'd12);
    rdIdx = 5'd13; #0.1; check("R7 cause 0x20", rdData, 32'h0000_0020);
    rdIdx = 5'd14; #0.1; check("R7 epc", rdData, 32'h0000_1000);
    rdIdx = 5'd5;  #0.1; check("R9 write dropped", rdData, 32'd0);
    // R7: delay slot trap
    excEn = 1; excCode = 5'd4; excSlot = 1; excPc = 32'h0000_2008;
    cycle("R7 slot trap", 5'd14);
    rdIdx = 5'd14; #0.1; check("R7 epc slot", rdData, 32'h0000_2004);
    rdIdx = 5'd13; #0.1; check("R7 cause slot", rdData, 32'h8000_0010);
    // R9: return beats index-12 write; other write proceeds
    rfeEn = 1; wrEn = 1; wrIdx = 5'd12; wrData = 32'h5555_5555;
    cycle("R9 rfe vs status write", 5'd12);
    rfeEn = 1; wrEn = 1; wrIdx = 5'd7; wrData = 32'h0BAD_F00D;
    cycle("R9 rfe with other write", 5'd7);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = $urandom_range(0, 3);
      wrEn = $urandom_range(0, 1);
      wrIdx = sel == 0 ? 5'd12 : sel == 1 ? 5'd13 : sel == 2 ? 5'd14 : 5'($urandom);
      wrData = $urandom;
      rfeEn = $urandom_range(0, 4) == 0;
      excEn = $urandom_range(0, 6) == 0;
      excCode = 5'($urandom);
      excSlot = $urandom_range(0, 1);
      excPc = {$urandom, 2'b00} & 32'hFFFF_FFFC;
      cycle("R4 R6 R7 random", $urandom_range(0, 2) == 0 ? 5'($urandom) : 5'(12 + $urandom_range(0, 2)));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule